// File: doc/BRIEF.md
# Pulse-Train Period and Duty Count Converter

This block turns a requested pulse train, given as a period, a time-unit code and a duty percentage, into the programming values for one timer channel. The outputs are a mode word that carries the chosen count-source code, a hold count, a load count and an output behaviour. The behaviour is one of three: steady low, steady high or pulsing. A caller presents the request with a one-cycle `start` strobe and waits for the one-cycle `done` pulse. On that pulse, `err` tells whether the request could not be served.

The period is first scaled to microseconds. That value places the request in one of five decade ranges, and each range has its own count source and prescale divisor. Two divisions are needed: one by the range's decade and one by 100 for the duty share. Both run on a single shared restoring divider, one quotient bit per clock. The results are registered and stay on the outputs until the next request completes.

Top module: `pulse_count_conv`

## Requirements
- R1: A duty of 0 finishes with `err`=0 and `out_mode`=2'b00 (steady low). `mode_word`, `hold_cnt` and `load_cnt` are all 0.
- R2: A duty of exactly 100 finishes with `err`=0 and `out_mode`=2'b01 (steady high). `mode_word`, `hold_cnt` and `load_cnt` are all 0.
- R3: The period is converted to microseconds by multiplying it by the unit code's scale: code 0 scales by 1, code 1 by 1000 and code 2 by 1000000. Code 3 is an error. Any error finishes with `err`=1, `out_mode`=2'b00 and all counts and `mode_word` equal to 0.
- R4: A request with a duty from 1 to 99 is an error when its period is 10 µs or less. It is also an error when its period is 100000000 µs or more.
- R5: The decade index k is 0 to 4 for periods below 10^4, 10^5, 10^6, 10^7 and 10^8 µs respectively. For a pulsing result, `mode_word` = 16'h0062 with bits 11:8 set to 4'hB+k, and `out_mode`=2'b10.
- R6: The total count is (period_us / 10^k) * 4. `hold_cnt` = (total * duty) / 100 + 1. Both divisions truncate.
- R7: `load_cnt` = total − `hold_cnt` + 2.
- R8: A duty above 100 is an error.
- R9: `done` is high for exactly one cycle per accepted request. The result outputs change only together with `done` and keep their values between completions.
- R10: A `start` that arrives while a request is in progress is ignored. A `start` that arrives in the same cycle as `done` is accepted as a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe; accepted only when idle |
| period_val | input | PER_W (32) | Period in the selected unit |
| time_unit | input | 2 | Unit code: 0 µs, 1 ms, 2 s, 3 invalid |
| duty_pct | input | 7 | Duty cycle percentage |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected |
| out_mode | output | 2 | 00 steady low, 01 steady high, 10 pulsing |
| mode_word | output | 16 | Channel mode with source code in bits 11:8 |
| hold_cnt | output | CNT_W (32) | Hold count |
| load_cnt | output | CNT_W (32) | Load count |

## Verification
The completion pulse of one request and the acceptance of the next can fall in the same cycle. The bench provokes this by watching for `done` and raising `start` with new operands before the following clock edge. It checks that the first result was intact when `done` was seen and that the second request then produces its own correct result. It also raises `start` in the middle of a computation and confirms that the answer still belongs to the original request.

// File: rtl/pcv_pkg.sv
package pcv_pkg;
  localparam int NUM_RANGES = 5;
  localparam logic [3:0] SRC_BASE = 4'hB;
  localparam logic [15:0] MODE_BASE = 16'h0062;

  typedef enum logic [1:0] {
    OM_OFF   = 2'b00,
    OM_ON    = 2'b01,
    OM_PULSE = 2'b10
  } omode_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_DIV_DEC, ST_DIV_PCT
  } cstate_t;

  // microsecond multiplier for a time-unit code (code 3 unused)
  function automatic logic [19:0] unit_scale(input logic [1:0] code);
    case (code)
      2'd0:    unit_scale = 20'd1;
      2'd1:    unit_scale = 20'd1000;
      default: unit_scale = 20'd1000000;
    endcase
  endfunction

  // 10 to the power n
  function automatic logic [31:0] pow10(input int n);
    logic [31:0] v;
    v = 32'd1;
    for (int i = 0; i < n; i++) v = v * 32'd10;
    return v;
  endfunction

  // mode word for decade index k
  function automatic logic [15:0] mode_for(input logic [2:0] k);
    logic [3:0] src;
    src = SRC_BASE + {1'b0, k};
    return MODE_BASE | {4'h0, src, 8'h00};
  endfunction
endpackage

// File: rtl/pcv_divider.sv
module pcv_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         fin,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, dsr_q, dvd_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [W:0]    trial;

  assign trial    = {rem_q, quo_q[W-1]};
  assign quotient = quo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0; quo_q <= '0; dsr_q <= '0; dvd_q <= '0;
      cnt_q <= '0; run_q <= 1'b0; fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        rem_q <= '0;
        quo_q <= dividend;
        dvd_q <= dividend;
        dsr_q <= divisor;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (trial >= {1'b0, dsr_q}) begin
          rem_q <= W'(trial - {1'b0, dsr_q});
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= trial[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          fin   <= 1'b1;
        end
      end
    end
  end

  // R6
  div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> divisor != '0);
  // R6
  div_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> ((2*W)'(quo_q) * (2*W)'(dsr_q) <= (2*W)'(dvd_q)) &&
            ((2*W)'(dvd_q) - (2*W)'(quo_q) * (2*W)'(dsr_q) < (2*W)'(dsr_q)));
endmodule

// File: rtl/pcv_range.sv
module pcv_range #(
  parameter int US_W = 52
) (
  input  logic [US_W-1:0] period_us,
  output logic            in_range,
  output logic [2:0]      dec_idx,
  output logic [31:0]     dec_div
);
  import pcv_pkg::*;

  logic [NUM_RANGES-1:0] below;

  generate
    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_thr
      assign below[g] = period_us < US_W'(pow10(4 + g));
    end
  endgenerate

  always_comb begin
    dec_idx = 3'd0;
    for (int i = NUM_RANGES - 1; i >= 0; i--)
      if (below[i]) dec_idx = 3'(i);
    in_range = below[NUM_RANGES-1] && (period_us > US_W'(10));
    dec_div  = pow10(int'(dec_idx));
  end
endmodule

// File: rtl/pulse_count_conv.sv
module pulse_count_conv #(
  parameter int PER_W = 32,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PER_W-1:0] period_val,
  input  logic [1:0]       time_unit,
  input  logic [6:0]       duty_pct,
  output logic             done,
  output logic             err,
  output logic [1:0]       out_mode,
  output logic [15:0]      mode_word,
  output logic [CNT_W-1:0] hold_cnt,
  output logic [CNT_W-1:0] load_cnt
);
  import pcv_pkg::*;

  localparam int US_W = PER_W + 20;

  cstate_t          state_q;
  logic [PER_W-1:0] per_q;
  logic [1:0]       unit_q;
  logic [6:0]       duty_q;
  logic [2:0]       idx_q;
  logic [CNT_W-1:0] total_q;
  logic             div_go;
  logic [CNT_W-1:0] div_a, div_b, div_q;
  logic             div_fin;

  logic [US_W-1:0]  per_us;
  logic             in_range;
  logic [2:0]       dec_idx;
  logic [31:0]      dec_div;

  // named events for the checks
  logic             accept_ev, finish_ev;

  assign per_us    = US_W'(per_q) * US_W'(unit_scale(unit_q));
  assign accept_ev = start && (state_q == ST_IDLE);

  pcv_range #(.US_W(US_W)) u_range (
    .period_us(per_us), .in_range(in_range),
    .dec_idx(dec_idx), .dec_div(dec_div)
  );

  pcv_divider #(.W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go),
    .dividend(div_a), .divisor(div_b),
    .fin(div_fin), .quotient(div_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      per_q <= '0; unit_q <= '0; duty_q <= '0; idx_q <= '0;
      total_q <= '0; div_go <= 1'b0; div_a <= '0; div_b <= '0;
      done <= 1'b0; finish_ev <= 1'b0; err <= 1'b0; out_mode <= OM_OFF;
      mode_word <= '0; hold_cnt <= '0; load_cnt <= '0;
    end else begin
      done      <= 1'b0;
      finish_ev <= 1'b0;
      div_go    <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          per_q   <= period_val;
          unit_q  <= time_unit;
          duty_q  <= duty_pct;
          state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          if (unit_q == 2'd3 || duty_q > 7'd100 ||
              (duty_q != 7'd0 && duty_q != 7'd100 && !in_range)) begin
            done <= 1'b1; finish_ev <= 1'b1; err <= 1'b1; out_mode <= OM_OFF;
            mode_word <= '0; hold_cnt <= '0; load_cnt <= '0;
            state_q <= ST_IDLE;
          end else if (duty_q == 7'd0 || duty_q == 7'd100) begin
            done <= 1'b1; finish_ev <= 1'b1; err <= 1'b0;
            out_mode <= (duty_q == 7'd0) ? OM_OFF : OM_ON;
            mode_word <= '0; hold_cnt <= '0; load_cnt <= '0;
            state_q <= ST_IDLE;
          end else begin
            idx_q   <= dec_idx;
            div_a   <= CNT_W'(per_us);
            div_b   <= CNT_W'(dec_div);
            div_go  <= 1'b1;
            state_q <= ST_DIV_DEC;
          end
        end
        ST_DIV_DEC: if (div_fin) begin
          total_q <= {div_q[CNT_W-3:0], 2'b00};
          div_a   <= CNT_W'({div_q[CNT_W-3:0], 2'b00} * CNT_W'(duty_q));
          div_b   <= CNT_W'(100);
          div_go  <= 1'b1;
          state_q <= ST_DIV_PCT;
        end
        ST_DIV_PCT: if (div_fin) begin
          done <= 1'b1; finish_ev <= 1'b1; err <= 1'b0; out_mode <= OM_PULSE;
          mode_word <= mode_for(idx_q);
          hold_cnt  <= div_q + 1'b1;
          load_cnt  <= total_q - (div_q + 1'b1) + CNT_W'(2);
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(hold_cnt) && $stable(load_cnt) && $stable(out_mode) && $stable(err));
  // R3
  err_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> out_mode == OM_OFF && hold_cnt == '0 && load_cnt == '0);
  // R5
  pulse_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && out_mode == OM_PULSE) |-> !err && mode_word[7:0] == 8'h62 &&
      mode_word[11:8] >= 4'hB && hold_cnt != '0);
  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state_q != ST_IDLE) |=> $stable(per_q) && $stable(duty_q));
  // R9
  accept_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> !finish_ev);
endmodule

// File: tb/pulse_count_conv_bench.sv
module pulse_count_conv_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] period_val = '0;
  logic [1:0]  time_unit = '0;
  logic [6:0]  duty_pct = '0;
  logic        done, err;
  logic [1:0]  out_mode;
  logic [15:0] mode_word;
  logic [31:0] hold_cnt, load_cnt;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  pulse_count_conv u_pulse_count_conv (
    .clk(clk), .rst_n(rst_n), .start(start), .period_val(period_val),
    .time_unit(time_unit), .duty_pct(duty_pct), .done(done), .err(err),
    .out_mode(out_mode), .mode_word(mode_word),
    .hold_cnt(hold_cnt), .load_cnt(load_cnt)
  );

  // expected results computed from the requirements
  logic        e_err;
  logic [1:0]  e_mode;
  logic [15:0] e_word;
  logic [31:0] e_hold, e_load;

  task automatic model(input logic [31:0] p, input logic [1:0] u, input logic [6:0] d);
    longint us, tot, h, dec;
    int k;
    e_err = 0; e_mode = 2'b00; e_word = 0; e_hold = 0; e_load = 0;
    us = longint'(p) * ((u == 0) ? 1 : (u == 1) ? 1000 : 1000000);
    if (u == 3 || d > 100) e_err = 1;
    else if (d == 0) e_mode = 2'b00;
    else if (d == 100) e_mode = 2'b01;
    else if (us <= 10 || us >= 100000000) e_err = 1;
    else begin
      k = 0; dec = 1;
      while (us >= dec * 10000) begin k++; dec = dec * 10; end
      tot = (us / dec) * 4;
      h = (tot * d) / 100 + 1;
      e_mode = 2'b10;
      e_word = 16'h0062 | 16'((11 + k) << 8);
      e_hold = 32'(h);
      e_load = 32'(tot - h + 2);
    end
  endtask

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    check(req, "err", err, e_err);
    check(req, "out_mode", out_mode, e_mode);
    check(req, "mode_word", mode_word, e_word);
    check(req, "hold_cnt", hold_cnt, e_hold);
    check(req, "load_cnt", load_cnt, e_load);
  endtask

  task automatic kick(input logic [31:0] p, input logic [1:0] u, input logic [6:0] d);
    period_val = p; time_unit = u; duty_pct = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 300) begin @(negedge clk); n++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL %s done actual=0 expected=1", req);
    end
  endtask

  task automatic run_case(input string req, input logic [31:0] p, input logic [1:0] u, input logic [6:0] d);
    kick(p, u, d);
    wait_done(req);
    model(p, u, d);
    compare(req);
    @(negedge clk);
  endtask

  // R9: one-cycle done, results held afterwards
  task automatic t_hold();
    kick(32'd7000, 2'd0, 7'd25);
    wait_done("R9");
    model(32'd7000, 2'd0, 7'd25);
    repeat (5) @(negedge clk);
    check("R9", "done_low", done, 0);
    compare("R9");
  endtask

  // R10: start while busy is ignored
  task automatic t_busy();
    kick(32'd250, 2'd1, 7'd40);
    repeat (4) @(negedge clk);
    kick(32'd11, 2'd0, 7'd90);
    wait_done("R10");
    model(32'd250, 2'd1, 7'd40);
    compare("R10");
    @(negedge clk);
    check("R10", "no_second_done", done, 0);
  endtask

  // R10: start in the done cycle is accepted
  task automatic t_b2b();
    kick(32'd3, 2'd2, 7'd60);
    wait_done("R10");
    model(32'd3, 2'd2, 7'd60);
    compare("R10");
    period_val = 32'd45000; time_unit = 2'd0; duty_pct = 7'd10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R10");
    model(32'd45000, 2'd0, 7'd10);
    compare("R10");
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9", "reset_done", done, 0);
    check("R3", "reset_err", err, 0);
    check("R1", "reset_hold", hold_cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_case("R1", 32'd500, 2'd0, 7'd0);
    run_case("R2", 32'd500, 2'd0, 7'd100);
    run_case("R3", 32'd5, 2'd1, 7'd50);
    run_case("R3", 32'd2, 2'd2, 7'd50);
    run_case("R3", 32'd500, 2'd3, 7'd50);
    run_case("R3", 32'hFFFFFFFF, 2'd2, 7'd50);
    run_case("R4", 32'd10, 2'd0, 7'd50);
    run_case("R4", 32'd11, 2'd0, 7'd99);
    run_case("R4", 32'd100, 2'd2, 7'd50);
    run_case("R4", 32'd99999999, 2'd0, 7'd1);
    run_case("R5", 32'd9999, 2'd0, 7'd50);
    run_case("R5", 32'd10000, 2'd0, 7'd50);
    run_case("R5", 32'd99999, 2'd0, 7'd50);
    run_case("R5", 32'd100000, 2'd0, 7'd50);
    run_case("R5", 32'd1000000, 2'd0, 7'd50);
    run_case("R5", 32'd10000000, 2'd0, 7'd50);
    run_case("R6", 32'd12345, 2'd0, 7'd33);
    run_case("R7", 32'd987, 2'd1, 7'd77);
    run_case("R8", 32'd500, 2'd0, 7'd101);
    t_hold();
    t_busy();
    t_b2b();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule